// File: doc/BRIEF.md
# SPI Message-Mode Master Controller

This block is an SPI master that runs one complete message per command and holds a single chip select low from the first bit to the last. Software loads bytes into a transmit buffer. It sets the serial clock rate and the clock polarity and phase in a configuration register. It then writes a message-control word, which gives the total byte count and the message type, and a command word, which gives the start opcode, a prepend count and the target device. The block shifts the message out and stores received bytes in a separate receive buffer. When the message ends it raises a command-done status bit, and an interrupt line carries that bit through a mask.

Three message types exist: full duplex, half-duplex write and half-duplex read. A half-duplex read may open with a write-only prepend of up to 15 bytes taken from the head of the transmit buffer. The prepend is typically a command or address sent to the target. The read bytes that follow land in the receive buffer from slot 0, and the prepend bytes take no receive slot. A prepend read may therefore total the buffer depth plus 15 bytes.

Top module: `spim_msg_master`

## Requirements
- R1: A register write to the command register (address 1) whose bits [1:0] equal 2'b01, made while idle, makes `busy` high and drives low only `cs_n[d]` on the next clock edge, where d is command bits [10:8]. Any other opcode value starts nothing.
- R2: Message type 2'b11 (message-control bits [15:14]) is full duplex. It sends transmit-buffer bytes 0..n-1, MSB first, where n is message-control bits [6:0]. The byte received at position i is stored in receive slot i.
- R3: Message type 2'b01 is a half-duplex write. It sends transmit bytes 0..n-1 and leaves the receive buffer unchanged. A nonzero prepend count has no effect with this type or with type 2'b11.
- R4: Message type 2'b10 is a half-duplex read with prepend count p (command bits [7:4]). Transmit bytes 0..p-1 are sent first, then n-p bytes with MOSI held low. The bytes read during those n-p positions fill receive slots 0..n-p-1.
- R5: A prepend read may carry DEPTH+15 bytes in total (79 with the defaults), filling every receive slot.
- R6: The chip select stays low for the whole message. It rises on the same clock edge on which `busy` falls.
- R7: Bit 0 of the interrupt status register (address 3) is set when a message ends. Writing 16'h00FF to that register clears it, and any other written value leaves it set. `irq` equals status bit 0 AND mask bit 0 (address 4).
- R8: Configuration bits [2:0] (address 2) select the SCK half-period in system clocks: code 0 gives 5, code 1 gives 8, code 2 gives 16, code 3 gives 32, code 4 gives 64, code 5 gives 128, and codes 6 and 7 give 256.
- R9: Configuration bit 3 sets the SCK idle level (polarity). Configuration bit 4 set to 0 samples MISO on the leading edge and changes MOSI on the trailing edge; set to 1 it does the reverse.
- R10: A command written while `busy` is high is ignored. The running message keeps its device and byte count, and no new message follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr |
| txb_we | input | 1 | Transmit buffer write strobe |
| txb_addr | input | 6 | Transmit buffer write address |
| txb_wdata | input | 8 | Transmit buffer write data |
| rxb_addr | input | 6 | Receive buffer read address |
| rxb_rdata | output | 8 | Receive buffer data at rxb_addr |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 8 | Active-low chip selects |
| busy | output | 1 | High while a message runs |
| irq | output | 1 | Masked command-done interrupt |

## Verification
`busy` and the selected chip select respond on the first clock edge after the command write. The bench therefore samples them at the falling edge that ends the write cycle. `busy` falls, the chip select rises and the done bit sets on one shared edge, so the bench polls `busy` at falling edges and checks the other two at the first falling edge where `busy` reads low. The serial data are judged by a bench slave that acts on the SCK edges themselves, and the half-period is measured as time between SCK edges divided by the clock period. Buffer and register contents are read through their combinational read ports one nanosecond after a falling edge.

// File: rtl/spim_pkg.sv
`timescale 1ns/1ps
package spim_pkg;

  typedef enum logic [1:0] {
    MT_NONE = 2'b00,
    MT_WR   = 2'b01,
    MT_RD   = 2'b10,
    MT_FD   = 2'b11
  } msg_type_e;

  localparam logic [1:0]  OP_START      = 2'b01;
  localparam logic [15:0] ISTAT_CLR_ALL = 16'h00FF;

  localparam logic [2:0] A_MCTL  = 3'd0;
  localparam logic [2:0] A_CMD   = 3'd1;
  localparam logic [2:0] A_CFG   = 3'd2;
  localparam logic [2:0] A_ISTAT = 3'd3;
  localparam logic [2:0] A_IMASK = 3'd4;
  localparam logic [2:0] A_STAT  = 3'd5;

  // System clocks per SCK half-period for a rate code.
  function automatic int unsigned sck_half_cycles(input logic [2:0] code);
    if (code == 3'd0)      return 5;
    else if (code == 3'd7) return 256;
    else                   return 4 << code;
  endfunction

  // Does byte position idx put transmit data on MOSI?
  function automatic logic byte_drives_tx(input msg_type_e t, input int unsigned idx,
                                          input int unsigned prep);
    return (t != MT_RD) || (idx < prep);
  endfunction

  // Is the byte received at position idx kept in the receive buffer?
  function automatic logic byte_is_stored(input msg_type_e t, input int unsigned idx,
                                          input int unsigned prep);
    return (t == MT_FD) || ((t == MT_RD) && (idx >= prep));
  endfunction

endpackage

// File: rtl/spim_tick.sv
`timescale 1ns/1ps
module spim_tick import spim_pkg::*; #(
  parameter int CW = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [2:0] code,
  output logic       tick
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last_val;

  assign last_val = CW'(sck_half_cycles(code) - 1);
  assign tick     = run && (cnt_q == last_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (!run || tick) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  // R8
  half_period_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= last_val));
endmodule

// File: rtl/spim_regs.sv
`timescale 1ns/1ps
module spim_regs import spim_pkg::*; #(
  parameter int MCTL_W   = 16,
  parameter int TYPE_POS = 14,
  parameter int CNT_W    = 7,
  parameter int DEV_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [2:0]       addr,
  input  logic [15:0]      wdata,
  output logic [15:0]      rdata,
  input  logic             busy,
  input  logic             done_evt,
  output logic             start,
  output logic [CNT_W-1:0] msg_cnt,
  output msg_type_e        msg_typ,
  output logic [3:0]       st_prep,
  output logic [DEV_W-1:0] st_dev,
  output logic [2:0]       rate,
  output logic             cpol,
  output logic             cpha,
  output logic             irq
);
  logic [MCTL_W-1:0] mctl_q;
  logic [15:0]       cmd_q;
  logic [4:0]        cfg_q;
  logic              ist_q;
  logic              imask_q;
  logic              cmd_wr;
  logic              clr_all;

  assign cmd_wr  = we && (addr == A_CMD);
  assign start   = cmd_wr && (wdata[1:0] == OP_START) && !busy;
  assign clr_all = we && (addr == A_ISTAT) && (wdata == ISTAT_CLR_ALL);

  assign msg_cnt = mctl_q[CNT_W-1:0];
  assign msg_typ = msg_type_e'(mctl_q[TYPE_POS +: 2]);
  assign st_prep = wdata[7:4];
  assign st_dev  = wdata[8 +: DEV_W];
  assign rate    = cfg_q[2:0];
  assign cpol    = cfg_q[3];
  assign cpha    = cfg_q[4];
  assign irq     = ist_q && imask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mctl_q  <= '0;
      cmd_q   <= '0;
      cfg_q   <= '0;
      imask_q <= 1'b0;
    end else if (we) begin
      if (addr == A_MCTL)      mctl_q  <= wdata[MCTL_W-1:0];
      if (cmd_wr && !busy)     cmd_q   <= wdata;
      if (addr == A_CFG)       cfg_q   <= wdata[4:0];
      if (addr == A_IMASK)     imask_q <= wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ist_q <= 1'b0;
    else if (done_evt) ist_q <= 1'b1;
    else if (clr_all)  ist_q <= 1'b0;
  end

  always_comb begin
    case (addr)
      A_MCTL:  rdata = 16'(mctl_q);
      A_CMD:   rdata = cmd_q;
      A_CFG:   rdata = {11'b0, cfg_q};
      A_ISTAT: rdata = {15'b0, ist_q};
      A_IMASK: rdata = {15'b0, imask_q};
      A_STAT:  rdata = {15'b0, busy};
      default: rdata = 16'h0000;
    endcase
  end

  // R7
  done_sets_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> ist_q);
  // R7
  clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_all && !done_evt) |=> !ist_q);
endmodule

// File: rtl/spim_engine.sv
`timescale 1ns/1ps
module spim_engine import spim_pkg::*; #(
  parameter int DEPTH = 64,
  parameter int CNT_W = 7,
  parameter int NCS   = 8,
  parameter int DEV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] st_cnt,
  input  msg_type_e        st_typ,
  input  logic [3:0]       st_prep,
  input  logic [DEV_W-1:0] st_dev,
  input  logic [2:0]       st_rate,
  input  logic             st_cpol,
  input  logic             st_cpha,
  input  logic             tick,
  output logic [2:0]       rate_q,
  output logic             busy,
  output logic [CNT_W-1:0] tx_ridx,
  input  logic [7:0]       tx_rdata,
  output logic             rx_we,
  output logic [CNT_W-1:0] rx_widx,
  output logic [7:0]       rx_wdata,
  output logic             done_evt,
  output logic             sck,
  output logic             mosi,
  input  logic             miso,
  output logic [NCS-1:0]   cs_n
);
  logic             busy_q, h_q, cpol_q, cpha_q;
  msg_type_e        typ_q;
  logic [CNT_W-1:0] cnt_q, prep_q, idx_q, nxt_idx, prep_eff;
  logic [DEV_W-1:0] dev_q;
  logic [2:0]       bit_q;
  logic [7:0]       txsh_q, rxsh_q;
  logic             byte_end, last_byte, fin;

  assign prep_eff  = (st_typ == MT_RD) ? CNT_W'(st_prep) : '0;
  assign nxt_idx   = idx_q + 1'b1;
  assign byte_end  = busy_q && tick && h_q && (bit_q == 3'd7);
  assign last_byte = (idx_q == cnt_q - 1'b1);
  assign fin       = byte_end && last_byte;
  assign done_evt  = fin || (start && !busy_q && (st_cnt == '0));
  assign tx_ridx   = busy_q ? nxt_idx : '0;
  assign busy      = busy_q;

  assign rx_widx  = idx_q - prep_q;
  assign rx_wdata = rxsh_q;
  assign rx_we    = byte_end && byte_is_stored(typ_q, int'(idx_q), int'(prep_q))
                    && (rx_widx < CNT_W'(DEPTH));

  assign sck  = busy_q ? (cpol_q ^ h_q ^ cpha_q) : st_cpol;
  assign mosi = busy_q && txsh_q[7];

  for (genvar i = 0; i < NCS; i++) begin : g_cs
    assign cs_n[i] = !(busy_q && (dev_q == DEV_W'(i)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; h_q <= 1'b0; cpol_q <= 1'b0; cpha_q <= 1'b0;
      typ_q <= MT_NONE; cnt_q <= '0; prep_q <= '0; idx_q <= '0;
      dev_q <= '0; bit_q <= '0; rate_q <= '0; txsh_q <= '0; rxsh_q <= '0;
    end else if (start && !busy_q) begin
      if (st_cnt != '0) begin
        busy_q <= 1'b1;
        typ_q  <= st_typ;
        cnt_q  <= st_cnt;
        prep_q <= prep_eff;
        dev_q  <= st_dev;
        cpol_q <= st_cpol;
        cpha_q <= st_cpha;
        rate_q <= st_rate;
        h_q    <= 1'b0;
        bit_q  <= '0;
        idx_q  <= '0;
        txsh_q <= byte_drives_tx(st_typ, 0, int'(prep_eff)) ? tx_rdata : 8'h00;
      end
    end else if (busy_q && tick) begin
      if (!h_q) begin
        h_q    <= 1'b1;
        rxsh_q <= {rxsh_q[6:0], miso};
      end else begin
        h_q <= 1'b0;
        if (bit_q == 3'd7) begin
          bit_q <= '0;
          if (last_byte) begin
            busy_q <= 1'b0;
          end else begin
            idx_q  <= nxt_idx;
            txsh_q <= byte_drives_tx(typ_q, int'(nxt_idx), int'(prep_q)) ? tx_rdata : 8'h00;
          end
        end else begin
          bit_q  <= bit_q + 1'b1;
          txsh_q <= {txsh_q[6:0], 1'b0};
        end
      end
    end
  end

  // R6
  cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> (!busy_q && (&cs_n)));
  // R10
  dev_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !fin) |=> ($stable(dev_q) && $stable(cnt_q)));
  // R4
  rx_after_prepend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_we |-> ((typ_q == MT_FD) || (idx_q >= prep_q)));
  // R2
  byte_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_end && !fin) |=> (idx_q == $past(idx_q) + 1'b1));
endmodule

// File: rtl/spim_msg_master.sv
`timescale 1ns/1ps
module spim_msg_master import spim_pkg::*; #(
  parameter int DEPTH    = 64,
  parameter int NCS      = 8,
  parameter int MCTL_W   = 16,
  parameter int TYPE_POS = 14,
  localparam int AW      = $clog2(DEPTH),
  localparam int CNT_W   = $clog2(DEPTH + 16),
  localparam int DEV_W   = $clog2(NCS),
  localparam int TICK_W  = $clog2(256 + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we,
  input  logic [2:0]     reg_addr,
  input  logic [15:0]    reg_wdata,
  output logic [15:0]    reg_rdata,
  input  logic           txb_we,
  input  logic [AW-1:0]  txb_addr,
  input  logic [7:0]     txb_wdata,
  input  logic [AW-1:0]  rxb_addr,
  output logic [7:0]     rxb_rdata,
  output logic           sck,
  output logic           mosi,
  input  logic           miso,
  output logic [NCS-1:0] cs_n,
  output logic           busy,
  output logic           irq
);
  logic             start, done_evt, tick, cpol, cpha, rx_we;
  logic [CNT_W-1:0] msg_cnt, tx_ridx, rx_widx;
  msg_type_e        msg_typ;
  logic [3:0]       st_prep;
  logic [DEV_W-1:0] st_dev;
  logic [2:0]       rate, rate_q;
  logic [7:0]       tx_rdata, rx_wdata;
  logic [7:0]       txm [DEPTH];
  logic [7:0]       rxm [DEPTH];

  spim_regs #(.MCTL_W(MCTL_W), .TYPE_POS(TYPE_POS), .CNT_W(CNT_W), .DEV_W(DEV_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .busy(busy), .done_evt(done_evt), .start(start),
    .msg_cnt(msg_cnt), .msg_typ(msg_typ), .st_prep(st_prep), .st_dev(st_dev),
    .rate(rate), .cpol(cpol), .cpha(cpha), .irq(irq));

  spim_tick #(.CW(TICK_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(busy), .code(rate_q), .tick(tick));

  spim_engine #(.DEPTH(DEPTH), .CNT_W(CNT_W), .NCS(NCS), .DEV_W(DEV_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(start), .st_cnt(msg_cnt), .st_typ(msg_typ),
    .st_prep(st_prep), .st_dev(st_dev), .st_rate(rate), .st_cpol(cpol),
    .st_cpha(cpha), .tick(tick), .rate_q(rate_q), .busy(busy), .tx_ridx(tx_ridx),
    .tx_rdata(tx_rdata), .rx_we(rx_we), .rx_widx(rx_widx), .rx_wdata(rx_wdata),
    .done_evt(done_evt), .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n));

  assign tx_rdata  = (tx_ridx < CNT_W'(DEPTH)) ? txm[tx_ridx[AW-1:0]] : 8'h00;
  assign rxb_rdata = rxm[rxb_addr];

  always_ff @(posedge clk) begin
    if (txb_we) txm[txb_addr] <= txb_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) rxm[i] <= 8'h00;
    end else if (rx_we) begin
      rxm[rx_widx[AW-1:0]] <= rx_wdata;
    end
  end
endmodule

// File: tb/tb_spim_msg_master.sv
`timescale 1ns/1ps
module tb_spim_msg_master;
  localparam int DEPTH = 64;
  localparam int NCS   = 8;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        txb_we = 1'b0;
  logic [5:0]  txb_addr = '0, rxb_addr = '0;
  logic [7:0]  txb_wdata = '0, rxb_rdata;
  logic        sck, mosi, miso = 1'b0, busy, irq;
  logic [NCS-1:0] cs_n;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  spim_msg_master dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .txb_we(txb_we),
    .txb_addr(txb_addr), .txb_wdata(txb_wdata), .rxb_addr(rxb_addr),
    .rxb_rdata(rxb_rdata), .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n),
    .busy(busy), .irq(irq));

  // ---------------- slave model ----------------
  logic [7:0] s_tx [128];
  logic [7:0] s_rx [128];
  int s_bits = 0, d_bits = 0;
  logic [NCS-1:0] s_cs = '1;
  logic cpol_cfg = 1'b0, cpha_cfg = 1'b0;
  logic cs_any;
  assign cs_any = &cs_n;

  always @(negedge cs_any) begin
    s_cs = cs_n; s_bits = 0; d_bits = 0;
    if (!cpha_cfg) begin miso = s_tx[0][7]; d_bits = 1; end
  end

  always @(sck) begin
    if (!cs_any) begin
      if ((sck != cpol_cfg) == !cpha_cfg) begin
        s_rx[(s_bits/8) % 128][7 - (s_bits % 8)] = mosi;
        s_bits++;
      end else begin
        miso = s_tx[(d_bits/8) % 128][7 - (d_bits % 8)];
        d_bits++;
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rrd(input logic [2:0] a, output logic [15:0] d);
    reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic txw(input int a, input logic [7:0] d);
    @(negedge clk); txb_we = 1'b1; txb_addr = 6'(a); txb_wdata = d;
    @(negedge clk); txb_we = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  function automatic logic [7:0] txpat(input int v, input int i);
    return 8'(60 + v * 17 + i * 29);
  endfunction

  function automatic int exp_half(input int c);
    case (c)
      0: return 5;   1: return 8;   2: return 16;  3: return 32;
      4: return 64;  5: return 128; default: return 256;
    endcase
  endfunction

  task automatic cfg_mode(input int rate, input bit cp, input bit ph);
    cpol_cfg = cp; cpha_cfg = ph;
    wr(3'd2, 16'({ph, cp, 3'(rate)}));
  endtask

  // {type[1:0], count[7:0], prepend[3:0], dev[2:0], rate[2:0], cpol, cpha}
  localparam logic [21:0] VEC [9] = '{
    {2'd3, 8'd4,  4'd0,  3'd0, 3'd0, 1'b0, 1'b0},  // full duplex, mode 0
    {2'd3, 8'd5,  4'd0,  3'd1, 3'd1, 1'b1, 1'b0},  // full duplex, mode 2
    {2'd1, 8'd3,  4'd0,  3'd2, 3'd0, 1'b0, 1'b1},  // write, mode 1
    {2'd2, 8'd4,  4'd0,  3'd3, 3'd0, 1'b1, 1'b1},  // read, no prepend, mode 3
    {2'd2, 8'd6,  4'd2,  3'd4, 3'd1, 1'b0, 1'b0},  // read with prepend
    {2'd2, 8'd79, 4'd15, 3'd5, 3'd0, 1'b0, 1'b1},  // R5 longest prepend read
    {2'd3, 8'd2,  4'd0,  3'd7, 3'd2, 1'b1, 1'b1},  // full duplex, mode 3
    {2'd1, 8'd3,  4'd5,  3'd6, 3'd0, 1'b0, 1'b0},  // write, prepend ignored
    {2'd3, 8'd3,  4'd3,  3'd0, 3'd0, 1'b0, 1'b0}   // full duplex, prepend ignored
  };

  logic [7:0] exp_rx [DEPTH];

  initial begin
    logic [15:0] r;
    logic [7:0]  b;
    for (int i = 0; i < DEPTH; i++) exp_rx[i] = 8'h00;
    for (int i = 0; i < 128; i++) begin s_tx[i] = 8'h00; s_rx[i] = 8'h00; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state
    chk(busy == 1'b0 && cs_n == '1, "R6 reset cs_n/busy", {cs_n, busy}, 9'h1FE);
    chk(irq == 1'b0 && sck == 1'b0, "R7 reset irq/sck", {irq, sck}, 0);
    rrd(3'd3, r); chk(r == 16'h0, "R7 reset status", r, 0);
    rxb_addr = 6'd0; #1 chk(rxb_rdata == 8'h00, "R2 reset rx buffer", rxb_rdata, 0);

    // Vector walk
    for (int v = 0; v < 9; v++) begin
      automatic int  typ  = int'(VEC[v][21:20]);
      automatic int  cnt  = int'(VEC[v][19:12]);
      automatic int  prep = int'(VEC[v][11:8]);
      automatic int  dev  = int'(VEC[v][7:5]);
      automatic int  rate = int'(VEC[v][4:2]);
      automatic int  p_eff = (typ == 2) ? prep : 0;
      automatic string tag = (typ == 3) ? "R2/R9" : (typ == 1) ? "R3/R9" : (cnt > DEPTH) ? "R5" : "R4/R9";
      automatic bit ok = 1;
      automatic int bad_a = 0, bad_e = 0;
      for (int i = 0; i < cnt && i < DEPTH; i++) txw(i, txpat(v, i));
      for (int i = 0; i < 128; i++) begin
        s_tx[i] = 8'hA5 ^ 8'(v * 13 + i * 7); s_rx[i] = 8'h00;
      end
      cfg_mode(rate, VEC[v][1], VEC[v][0]);
      wr(3'd0, 16'((typ << 14) | cnt));
      wr(3'd1, 16'((dev << 8) | (prep << 4) | 1));
      // R1 / R6: selected chip select low the edge after the command write
      chk(busy && cs_n == ~(NCS'(1) << dev), "R1 start cs_n", cs_n, ~(NCS'(1) << dev));
      wait_idle();
      chk(cs_n == '1, "R6 cs released with busy", cs_n, 8'hFF);
      rrd(3'd3, r); chk(r[0] == 1'b1, "R7 done bit", r, 1);
      chk(s_bits == 8 * cnt, {tag, " bit count"}, s_bits, 8 * cnt);
      for (int i = 0; i < cnt; i++) begin
        automatic logic [7:0] e = (typ == 2 && i >= prep) ? 8'h00 : txpat(v, i);
        if (s_rx[i] != e && ok) begin ok = 0; bad_a = s_rx[i]; bad_e = e; end
      end
      chk(ok, {tag, " mosi bytes"}, bad_a, bad_e);
      if (typ == 3) for (int i = 0; i < cnt; i++) exp_rx[i] = s_tx[i];
      if (typ == 2) for (int i = 0; i < cnt - p_eff; i++) exp_rx[i] = s_tx[p_eff + i];
      ok = 1;
      for (int i = 0; i < DEPTH; i++) begin
        rxb_addr = 6'(i); #1;
        if (rxb_rdata != exp_rx[i] && ok) begin ok = 0; bad_a = rxb_rdata; bad_e = exp_rx[i]; end
      end
      chk(ok, {tag, " rx buffer"}, bad_a, bad_e);
      wr(3'd3, 16'h00FF);
    end

    // R1: a command with another opcode starts nothing
    wr(3'd1, 16'h0003);
    chk(!busy && cs_n == '1, "R1 bad opcode", {cs_n, busy}, 9'h1FE);
    repeat (10) @(negedge clk);
    chk(!busy, "R1 bad opcode later", busy, 0);

    // R9: idle SCK follows polarity bit
    cfg_mode(0, 1'b1, 1'b0); @(negedge clk);
    chk(sck == 1'b1, "R9 idle sck high", sck, 1);
    cfg_mode(0, 1'b0, 1'b0); @(negedge clk);
    chk(sck == 1'b0, "R9 idle sck low", sck, 0);

    // R8: SCK half-period per rate code
    foreach (VEC[k]) ; // keep loop form simple
    for (int c = 0; c < 8; c += 1) begin
      realtime t0, t1;
      if (c != 0 && c != 2 && c != 5 && c != 7) continue;
      cfg_mode(c, 1'b0, 1'b0);
      wr(3'd0, 16'((1 << 14) | 1));
      wr(3'd1, 16'h0001);
      @(posedge sck); t0 = $realtime;
      @(negedge sck); t1 = $realtime;
      chk(int'((t1 - t0) / 5.0) == exp_half(c), "R8 half period", int'((t1 - t0) / 5.0), exp_half(c));
      wait_idle();
    end
    wr(3'd3, 16'h00FF);

    // R10: command while busy is ignored
    cfg_mode(0, 1'b0, 1'b0);
    wr(3'd0, 16'((3 << 14) | 3));
    wr(3'd1, 16'h0101);
    repeat (30) @(negedge clk);
    wr(3'd1, 16'h0201);
    chk(cs_n == 8'hFD, "R10 device kept", cs_n, 8'hFD);
    wait_idle();
    chk(s_bits == 24 && s_cs == 8'hFD, "R10 byte count kept", s_bits, 24);
    repeat (20) @(negedge clk);
    chk(!busy && cs_n == '1, "R10 no second message", {cs_n, busy}, 9'h1FE);

    // R7: mask, partial write and clear-all
    rrd(3'd3, r); chk(r[0] && !irq, "R7 masked irq", {irq, r[0]}, 1);
    wr(3'd4, 16'h0001);
    chk(irq == 1'b1, "R7 unmasked irq", irq, 1);
    wr(3'd3, 16'h0001);
    rrd(3'd3, r); chk(r[0] && irq, "R7 other value keeps bit", r, 1);
    wr(3'd3, 16'h00FF);
    rrd(3'd3, r); chk(!r[0] && !irq, "R7 clear all", {irq, r[0]}, 0);
    b = 8'h00;

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule